// File: doc/BRIEF.md
# Layer Window and Alpha Blender

This block sits in the pixel path of a display controller and handles one layer. A timing generator supplies the current raster position each pixel clock, together with a raw layer pixel in one of eight formats. The block decides whether that position falls inside a programmed rectangular window. The window corners are given relative to the accumulated back porch of each axis.

Inside the window the pixel is widened to 8 bits per channel with an alpha channel. It is then mixed over a background colour using a weight built from an 8-bit constant alpha and, when the format carries one, the pixel's own alpha. Outside the window a programmable default colour, with its own alpha, takes the place of the pixel. The block delivers one 24-bit RGB result per clock, with a fixed latency of two cycles. Clearing the layer enable makes the block show the background alone.

Top module: `layer_blend`

## Requirements
- R1: A position is inside horizontally when acc_hbp+1+win_x0 <= hpos <= acc_hbp+1+win_x1, with both edges inclusive and the sums taken without wrap-around.
- R2: A position is inside vertically when acc_vbp+1+win_y0 <= vpos <= acc_vbp+1+win_y1. The window is the intersection of both axes, and a window with win_x0 > win_x1 (or win_y0 > win_y1) contains no position.
- R3: The fmt codes are 0 ARGB8888, 1 RGB888, 2 RGB565, 3 ARGB1555, 4 ARGB4444, 5 L8, 6 AL44, 7 AL88. Fields sit at the low end of pix_in, with alpha highest. RGB565 has red at bits 15:11, green at 10:5 and blue at 4:0. AL44 has alpha at 7:4, AL88 has alpha at 15:8, and the luminance takes the low part.
- R4: A component narrower than 8 bits is widened by appending its top bits below it (5-bit v becomes {v,v[4:2]}, 6-bit v becomes {v,v[5:4]}, 4-bit v becomes {v,v}). The 1-bit alpha becomes 0x00 or 0xFF. Formats without alpha get alpha 0xFF. Luminance is copied to red, green and blue.
- R5: Inside the window the weight F is round(pa*ca/255) = (pa*ca+127)/255 for formats with alpha (0, 3, 4, 6, 7), and F = ca for the others, where ca is const_alpha.
- R6: Each output channel equals (F*C + (255-F)*B + 127)/255 in integer arithmetic, where C is the layer colour channel and B is the bg_rgb channel. So F=0xFF yields C and F=0 yields B.
- R7: Outside the window the colour is dflt_argb and F = (da*ca+127)/255, where da is dflt_argb[31:24], whatever the format.
- R8: When layer_en is 0, rgb_out equals bg_rgb at every position.
- R9: rgb_out reflects the inputs sampled two rising edges earlier, and a new pixel is accepted every cycle. A synchronous active-high rst drives rgb_out to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| layer_en | input | 1 | Layer enable |
| fmt | input | 3 | Pixel format code |
| pix_in | input | 32 | Raw layer pixel |
| hpos | input | CW | Raster column |
| vpos | input | CW | Raster row |
| acc_hbp | input | CW | Accumulated horizontal back porch |
| acc_vbp | input | CW | Accumulated vertical back porch |
| win_x0 | input | CW | Window first column (relative) |
| win_x1 | input | CW | Window last column (relative) |
| win_y0 | input | CW | Window first row (relative) |
| win_y1 | input | CW | Window last row (relative) |
| const_alpha | input | 8 | Constant alpha, 0xFF opaque |
| dflt_argb | input | 32 | Default colour outside the window |
| bg_rgb | input | 24 | Background colour beneath the layer |
| rgb_out | output | 24 | Blended pixel |

## Verification
The bench builds the block with CW=10, so the widest raster coordinate is 1023. This lets a window whose last column lands exactly on 1023 be placed with a back porch of 1000, which checks that the edge sums neither wrap nor drop the final column. Every format code, every window edge from both sides, the empty window, and partial weights from pixel alpha, constant alpha and their product are driven at this width.

// File: rtl/lw_pkg.sv
package lw_pkg;

    typedef enum logic [2:0] {
        FMT_ARGB8888 = 3'd0,
        FMT_RGB888   = 3'd1,
        FMT_RGB565   = 3'd2,
        FMT_ARGB1555 = 3'd3,
        FMT_ARGB4444 = 3'd4,
        FMT_L8       = 3'd5,
        FMT_AL44     = 3'd6,
        FMT_AL88     = 3'd7
    } pix_fmt_e;

    typedef struct packed {
        logic [7:0] a;
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } argb_t;

    // Registered state between window/expand and the mixer
    typedef struct packed {
        logic        en;
        argb_t       col;
        logic [7:0]  wgt;
        logic [23:0] bg;
    } stage_t;

    function automatic logic fmt_has_alpha(pix_fmt_e f);
        case (f)
            FMT_ARGB8888, FMT_ARGB1555, FMT_ARGB4444,
            FMT_AL44, FMT_AL88: return 1'b1;
            default:            return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] widen4(logic [3:0] v);
        return {v, v};
    endfunction

    function automatic logic [7:0] widen5(logic [4:0] v);
        return {v, v[4:2]};
    endfunction

    function automatic logic [7:0] widen6(logic [5:0] v);
        return {v, v[5:4]};
    endfunction

    // Exact integer quotient by 255, result known to fit 8 bits
    function automatic logic [7:0] div255(logic [15:0] num);
        logic [15:0] q;
        q = num / 16'd255;
        return q[7:0];
    endfunction

    // Rounded product of two unit fractions in 0..255
    function automatic logic [7:0] frac_mul(logic [7:0] x, logic [7:0] y);
        logic [15:0] p;
        p = 16'(x) * 16'(y) + 16'd127;
        return div255(p);
    endfunction

endpackage

// File: rtl/lw_span_hit.sv
module lw_span_hit #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] pos,
    input  logic [CW-1:0] porch,
    input  logic [CW-1:0] lo,
    input  logic [CW-1:0] hi,
    output logic          hit
);
    localparam int EW = CW + 2;

    logic [EW-1:0] first_pos;
    logic [EW-1:0] last_pos;
    logic [EW-1:0] pos_w;

    always_comb begin
        first_pos = EW'(porch) + EW'(lo) + EW'(1);
        last_pos  = EW'(porch) + EW'(hi) + EW'(1);
        pos_w     = EW'(pos);
        hit       = (pos_w >= first_pos) && (pos_w <= last_pos);
    end

    // R2: an inverted span never reports a hit
    a_r2_empty_span: assert property (@(posedge clk) disable iff (rst)
        (lo > hi) |-> !hit);

endmodule

// File: rtl/lw_pix_expand.sv
module lw_pix_expand
    import lw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pix_fmt_e fmt,
    input  logic [31:0] raw,
    output argb_t    px
);
    always_comb begin
        case (fmt)
            FMT_ARGB8888: px = raw;
            FMT_RGB888:   px = {8'hFF, raw[23:0]};
            FMT_RGB565:   px = {8'hFF, widen5(raw[15:11]), widen6(raw[10:5]),
                                widen5(raw[4:0])};
            FMT_ARGB1555: px = {{8{raw[15]}}, widen5(raw[14:10]),
                                widen5(raw[9:5]), widen5(raw[4:0])};
            FMT_ARGB4444: px = {widen4(raw[15:12]), widen4(raw[11:8]),
                                widen4(raw[7:4]), widen4(raw[3:0])};
            FMT_L8:       px = {8'hFF, raw[7:0], raw[7:0], raw[7:0]};
            FMT_AL44:     px = {widen4(raw[7:4]), widen4(raw[3:0]),
                                widen4(raw[3:0]), widen4(raw[3:0])};
            default:      px = {raw[15:8], raw[7:0], raw[7:0], raw[7:0]};
        endcase
    end

    // R4: formats without alpha come out opaque
    a_r4_opaque_no_alpha: assert property (@(posedge clk) disable iff (rst)
        !fmt_has_alpha(fmt) |-> (px.a == 8'hFF));

    // R4: luminance formats give grey
    a_r4_grey_lum: assert property (@(posedge clk) disable iff (rst)
        (fmt inside {FMT_L8, FMT_AL44, FMT_AL88}) |->
            (px.r == px.g && px.g == px.b));

endmodule

// File: rtl/lw_mixer.sv
module lw_mixer
    import lw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  wgt,
    input  argb_t       fg,
    input  logic [23:0] bg,
    output logic [23:0] mix
);
    localparam int NCH = 3;
    localparam int CHW = 8;

    logic [23:0] fg_rgb;
    logic [7:0]  inv_wgt;

    assign fg_rgb  = {fg.r, fg.g, fg.b};
    assign inv_wgt = 8'd255 - wgt;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        logic [15:0] num;
        always_comb begin
            num = 16'(wgt) * 16'(fg_rgb[ch*CHW +: CHW])
                + 16'(inv_wgt) * 16'(bg[ch*CHW +: CHW])
                + 16'd127;
            mix[ch*CHW +: CHW] = div255(num);
        end
    end

    // R6: full weight shows the layer colour unchanged
    a_r6_full_weight: assert property (@(posedge clk) disable iff (rst)
        (wgt == 8'hFF) |-> (mix == fg_rgb));

    // R6: zero weight shows the background unchanged
    a_r6_zero_weight: assert property (@(posedge clk) disable iff (rst)
        (wgt == 8'h00) |-> (mix == bg));

endmodule

// File: rtl/layer_blend.sv
module layer_blend
    import lw_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          layer_en,
    input  logic [2:0]    fmt,
    input  logic [31:0]   pix_in,
    input  logic [CW-1:0] hpos,
    input  logic [CW-1:0] vpos,
    input  logic [CW-1:0] acc_hbp,
    input  logic [CW-1:0] acc_vbp,
    input  logic [CW-1:0] win_x0,
    input  logic [CW-1:0] win_x1,
    input  logic [CW-1:0] win_y0,
    input  logic [CW-1:0] win_y1,
    input  logic [7:0]    const_alpha,
    input  logic [31:0]   dflt_argb,
    input  logic [23:0]   bg_rgb,
    output logic [23:0]   rgb_out
);
    localparam int LAT = 2;

    pix_fmt_e    fmt_e;
    logic        hit_h;
    logic        hit_v;
    logic        in_win;
    argb_t       px;
    argb_t       dflt;
    argb_t       src;
    logic [7:0]  wgt_c;
    stage_t      s1;
    logic [23:0] mix;

    assign fmt_e = pix_fmt_e'(fmt);
    assign dflt  = dflt_argb;

    lw_span_hit #(.CW(CW)) u_hit_h (
        .clk(clk), .rst(rst), .pos(hpos), .porch(acc_hbp),
        .lo(win_x0), .hi(win_x1), .hit(hit_h)
    );

    lw_span_hit #(.CW(CW)) u_hit_v (
        .clk(clk), .rst(rst), .pos(vpos), .porch(acc_vbp),
        .lo(win_y0), .hi(win_y1), .hit(hit_v)
    );

    assign in_win = hit_h & hit_v;

    lw_pix_expand u_expand (
        .clk(clk), .rst(rst), .fmt(fmt_e), .raw(pix_in), .px(px)
    );

    // Source colour and weight selection
    always_comb begin
        if (in_win) begin
            src   = px;
            wgt_c = fmt_has_alpha(fmt_e) ? frac_mul(px.a, const_alpha)
                                         : const_alpha;
        end else begin
            src   = dflt;
            wgt_c = frac_mul(dflt.a, const_alpha);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.en  <= layer_en;
            s1.col <= src;
            s1.wgt <= wgt_c;
            s1.bg  <= bg_rgb;
        end
    end

    lw_mixer u_mixer (
        .clk(clk), .rst(rst), .wgt(s1.wgt), .fg(s1.col),
        .bg(s1.bg), .mix(mix)
    );

    always_ff @(posedge clk) begin
        if (rst) rgb_out <= '0;
        else     rgb_out <= s1.en ? mix : s1.bg;
    end

    // Cycles since reset, saturating at the latency, for history checks
    logic [1:0] warm_cnt;
    always_ff @(posedge clk) begin
        if (rst)                  warm_cnt <= '0;
        else if (warm_cnt != 2'(LAT)) warm_cnt <= warm_cnt + 2'd1;
    end

    // R8: a disabled layer shows the background two cycles later
    a_r8_disabled_bg: assert property (@(posedge clk)
        disable iff (rst || warm_cnt != 2'(LAT))
        $past(!layer_en, 2) |-> (rgb_out == $past(bg_rgb, 2)));

    // R6: an opaque RGB888 pixel inside the window passes unchanged
    a_r6_opaque_pass: assert property (@(posedge clk)
        disable iff (rst || warm_cnt != 2'(LAT))
        $past(layer_en && in_win && const_alpha == 8'hFF &&
              fmt == 3'd1, 2) |-> (rgb_out == $past(pix_in[23:0], 2)));

    // R9: output is zero the cycle after a reset edge
    a_r9_reset_zero: assert property (@(posedge clk)
        $past(rst) |-> (rgb_out == 24'd0));

endmodule

// File: tb/layer_blend_bench.sv
module layer_blend_bench;

    localparam int CW = 10;
    localparam int NV = 20;

    typedef struct packed {
        logic [9:0]  h;
        logic [9:0]  v;
        logic [2:0]  fmt;
        logic [31:0] pix;
        logic [7:0]  ca;
        logic [23:0] exp;
    } vec_t;

    // Window: porch h=3 v=2, x 0..9, y 0..4 -> cols 4..13, rows 3..7
    // default FF445566, background 102030
    localparam vec_t TBL [NV] = '{
        '{10'd4,  10'd3, 3'd1, 32'h00AABBCC, 8'hFF, 24'hAABBCC}, // R1 R2 first corner
        '{10'd13, 10'd7, 3'd2, 32'h0000F800, 8'hFF, 24'hFF0000}, // R1 R2 last corner, R3
        '{10'd3,  10'd3, 3'd1, 32'h00AABBCC, 8'hFF, 24'h445566}, // R1 left of window, R7
        '{10'd14, 10'd7, 3'd1, 32'h00AABBCC, 8'hFF, 24'h445566}, // R1 right of window
        '{10'd13, 10'd8, 3'd1, 32'h00AABBCC, 8'hFF, 24'h445566}, // R2 below window
        '{10'd4,  10'd2, 3'd1, 32'h00AABBCC, 8'hFF, 24'h445566}, // R2 above window
        '{10'd8,  10'd5, 3'd0, 32'h00FFFFFF, 8'hFF, 24'h102030}, // R5 pixel alpha 0
        '{10'd8,  10'd5, 3'd0, 32'hFF123456, 8'hFF, 24'h123456}, // R5 pixel alpha FF
        '{10'd8,  10'd5, 3'd3, 32'h00007FFF, 8'hFF, 24'h102030}, // R4 1-bit alpha clear
        '{10'd8,  10'd5, 3'd3, 32'h0000FC00, 8'hFF, 24'hFF0000}, // R4 1-bit alpha set
        '{10'd8,  10'd5, 3'd5, 32'h0000005A, 8'hFF, 24'h5A5A5A}, // R4 L8 grey
        '{10'd8,  10'd5, 3'd7, 32'h0000FF3C, 8'hFF, 24'h3C3C3C}, // R3 AL88
        '{10'd8,  10'd5, 3'd6, 32'h000000F7, 8'hFF, 24'h777777}, // R3 AL44
        '{10'd8,  10'd5, 3'd4, 32'h0000F1A5, 8'hFF, 24'h11AA55}, // R4 4-bit widen
        '{10'd8,  10'd5, 3'd1, 32'h00AABBCC, 8'h00, 24'h102030}, // R6 zero weight
        '{10'd8,  10'd5, 3'd2, 32'h000007E0, 8'hFF, 24'h00FF00}, // R3 RGB565 green
        '{10'd8,  10'd5, 3'd2, 32'h00000821, 8'hFF, 24'h080408}, // R4 5/6-bit widen
        '{10'd8,  10'd5, 3'd1, 32'h00FFFFFF, 8'h80, 24'h889098}, // R5 R6 const alpha
        '{10'd8,  10'd5, 3'd0, 32'h80FFFFFF, 8'hFF, 24'h889098}, // R5 R6 pixel alpha
        '{10'd8,  10'd5, 3'd0, 32'h80FFFFFF, 8'h80, 24'h4C5864}  // R5 product of alphas
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          layer_en = 1'b1;
    logic [2:0]    fmt = 3'd1;
    logic [31:0]   pix_in = 32'h0;
    logic [CW-1:0] hpos = '0;
    logic [CW-1:0] vpos = '0;
    logic [CW-1:0] acc_hbp = 10'd3;
    logic [CW-1:0] acc_vbp = 10'd2;
    logic [CW-1:0] win_x0 = 10'd0;
    logic [CW-1:0] win_x1 = 10'd9;
    logic [CW-1:0] win_y0 = 10'd0;
    logic [CW-1:0] win_y1 = 10'd4;
    logic [7:0]    const_alpha = 8'hFF;
    logic [31:0]   dflt_argb = 32'hFF445566;
    logic [23:0]   bg_rgb = 24'h102030;
    logic [23:0]   rgb_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    layer_blend #(.CW(CW)) u_layer_blend (
        .clk(clk), .rst(rst), .layer_en(layer_en), .fmt(fmt),
        .pix_in(pix_in), .hpos(hpos), .vpos(vpos),
        .acc_hbp(acc_hbp), .acc_vbp(acc_vbp),
        .win_x0(win_x0), .win_x1(win_x1),
        .win_y0(win_y0), .win_y1(win_y1),
        .const_alpha(const_alpha), .dflt_argb(dflt_argb),
        .bg_rgb(bg_rgb), .rgb_out(rgb_out)
    );

    function automatic int ref_frac(int x, int y);
        return (x * y + 127) / 255;
    endfunction

    function automatic logic [23:0] ref_mix(int f, logic [23:0] c, logic [23:0] b);
        logic [23:0] r;
        for (int k = 0; k < 3; k++) begin
            int cv;
            int bv;
            cv = int'(c[k*8 +: 8]);
            bv = int'(b[k*8 +: 8]);
            r[k*8 +: 8] = 8'((f * cv + (255 - f) * bv + 127) / 255);
        end
        return r;
    endfunction

    task automatic chk(string req, logic [23:0] act, logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: rgb_out=%06h expected=%06h", req, act, exp);
        end
    endtask

    task automatic drive(logic [9:0] h, logic [9:0] v, logic [2:0] f,
                         logic [31:0] p, logic [7:0] ca);
        hpos = h; vpos = v; fmt = f; pix_in = p; const_alpha = ca;
    endtask

    // Drive at a falling edge, wait two rising edges, sample at next falling edge
    task automatic apply(logic [9:0] h, logic [9:0] v, logic [2:0] f,
                         logic [31:0] p, logic [7:0] ca);
        @(negedge clk);
        drive(h, v, f, p, ca);
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        // R9: reset holds the output at zero even with live stimulus
        drive(10'd8, 10'd5, 3'd1, 32'h00AABBCC, 8'hFF);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 reset", rgb_out, 24'h000000);
        rst = 1'b0;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            apply(TBL[i].h, TBL[i].v, TBL[i].fmt, TBL[i].pix, TBL[i].ca);
            chk($sformatf("table[%0d]", i), rgb_out, TBL[i].exp);
        end

        // R8: layer disabled shows background inside the window
        layer_en = 1'b0;
        apply(10'd8, 10'd5, 3'd0, 32'hFF123456, 8'hFF);
        chk("R8 disabled", rgb_out, 24'h102030);
        layer_en = 1'b1;

        // R7: default alpha 0 outside, for both alpha and non-alpha formats
        dflt_argb = 32'h00445566;
        apply(10'd20, 10'd5, 3'd0, 32'hFF123456, 8'hFF);
        chk("R7 dflt alpha 0 fmt0", rgb_out, 24'h102030);
        apply(10'd20, 10'd5, 3'd1, 32'h00123456, 8'hFF);
        chk("R7 dflt alpha 0 fmt1", rgb_out, 24'h102030);

        // R7: partial weight from default alpha times constant alpha
        dflt_argb = 32'hC0445566;
        apply(10'd20, 10'd5, 3'd1, 32'h00123456, 8'h80);
        chk("R7 dflt partial", rgb_out,
            ref_mix(ref_frac(8'hC0, 8'h80), 24'h445566, 24'h102030));
        dflt_argb = 32'hFF445566;

        // R2: inverted horizontal span gives no window
        win_x0 = 10'd5; win_x1 = 10'd2;
        apply(10'd6, 10'd5, 3'd1, 32'h00AABBCC, 8'hFF);
        chk("R2 empty window", rgb_out, 24'h445566);
        win_x0 = 10'd0; win_x1 = 10'd9;

        // R1: window ending on the widest column 1023
        acc_hbp = 10'd1000; win_x1 = 10'd22;
        apply(10'd1023, 10'd5, 3'd1, 32'h00AABBCC, 8'hFF);
        chk("R1 last column 1023", rgb_out, 24'hAABBCC);
        apply(10'd1000, 10'd5, 3'd1, 32'h00AABBCC, 8'hFF);
        chk("R1 porch column outside", rgb_out, 24'h445566);
        apply(10'd1001, 10'd5, 3'd1, 32'h00AABBCC, 8'hFF);
        chk("R1 first column", rgb_out, 24'hAABBCC);
        acc_hbp = 10'd3; win_x1 = 10'd9;

        // R9: back-to-back pixels, one per cycle, two-cycle latency
        @(negedge clk);
        drive(TBL[7].h, TBL[7].v, TBL[7].fmt, TBL[7].pix, TBL[7].ca);
        @(negedge clk);
        drive(TBL[2].h, TBL[2].v, TBL[2].fmt, TBL[2].pix, TBL[2].ca);
        @(negedge clk);
        drive(TBL[13].h, TBL[13].v, TBL[13].fmt, TBL[13].pix, TBL[13].ca);
        chk("R9 stream 0", rgb_out, TBL[7].exp);
        @(negedge clk);
        chk("R9 stream 1", rgb_out, TBL[2].exp);
        @(negedge clk);
        chk("R9 stream 2", rgb_out, TBL[13].exp);

        // R9: reset mid-stream clears the output after one edge
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R9 reset again", rgb_out, 24'h000000);
        rst = 1'b0;

        finish_run();
    end

endmodule